// File: doc/BRIEF.md
# Split-Byte CPU Register File

This block holds the architectural registers of a small processor whose data path is one byte wide but whose pointers and register pairs are two bytes wide. It stores an 8-bit accumulator and 8-bit flags. It also stores two 16-bit register pairs and three 16-bit pointer registers: stack, frame and program counter. Every register is chosen by a 4-bit code. A hard-wired zero register answers at either width.

Each pair can be reached as a full word or as its upper or lower byte alone. The flags byte and the lower byte of the second pair are the same storage. Writing either name changes both. Two combinational read ports serve the operand fetch, and one synchronous write port takes results. Values narrower than 16 bits come out zero-extended. The execution stage writes flags through a separate update input. The fetch stage advances the program counter by two, or loads it outright, through a dedicated path. The program counter is always visible on its own output.

Top module: `split_regfile`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every register is cleared, so after reset every read code returns 0x0000 and `pc_q` is 0x0000.
- R2: Code 0x0 selects the 8-bit accumulator. A write stores `wr_data[7:0]` and ignores `wr_data[15:8]`. Any 8-bit register read on a port is zero-extended, so bits [15:8] are 0.
- R3: Codes 0x2/0x3 write only the upper/lower byte of the first pair, and codes 0x4/0x5 write only the upper/lower byte of the second pair, each from `wr_data[7:0]`. The other byte keeps its value.
- R4: Codes 0x6 and 0x7 read and write the first and second pair as one word, upper byte in bits [15:8]. The byte codes then return the matching halves.
- R5: Code 0x1 (flags) and code 0x5 (second pair, lower byte) name the same storage. A write through one is seen through the other and in the lower byte of code 0x7.
- R6: Codes 0x8, 0x9 and 0xA read and write the 16-bit stack, frame and program counter registers. `pc_q` always shows the program counter.
- R7: Code 0xF reads 0x0000 on both ports, and a write to it changes no register.
- R8: Codes 0xB to 0xE read 0x0000, and a write to them changes no register.
- R9: With `flag_we` high and no write to the flags byte in that cycle, the flags byte takes `flag_d` at the clock edge.
- R10: If a port write to code 0x1, 0x5 or 0x7 and a flag update hit the flags byte in the same cycle, the port write is stored. A flag update during a write to any other code still takes effect.
- R11: The program counter priority is `pc_load` (takes `pc_load_val`), then a port write to code 0xA, then `pc_inc` (adds 2, wrapping modulo 2^16). With none of these active, it holds.
- R12: The two read ports decode their codes independently within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_sel_a | input | 4 | Register code for read port A |
| rd_data_a | output | 16 | Read port A data, zero-extended for 8-bit registers |
| rd_sel_b | input | 4 | Register code for read port B |
| rd_data_b | output | 16 | Read port B data, zero-extended for 8-bit registers |
| wr_en | input | 1 | Write port enable |
| wr_sel | input | 4 | Register code for the write port |
| wr_data | input | 16 | Write data; 8-bit targets use bits [7:0] |
| flag_we | input | 1 | Flags update enable |
| flag_d | input | 8 | New flags value |
| pc_inc | input | 1 | Advance program counter by 2 |
| pc_load | input | 1 | Load program counter from `pc_load_val` |
| pc_load_val | input | 16 | Program counter load value |
| pc_q | output | 16 | Current program counter |

## Verification
Byte writes go to each half of a pair and are then read back through the word code. The same is done in reverse. This shows whether the half-select and the upper/lower ordering are right. Writes through the flags name are followed by reads through the pair name, and the reverse. Flag updates are sent alone, together with a write to the same byte, and together with a write to the neighbouring upper byte. These three cases separate the shared storage from the write-wins rule and from a stray clobber. The zero code and the unused codes are written with all ones, and every other register is read afterwards. The program counter is driven with increment alone, increment with load, increment with a port write, load with a port write, and increment from 0xFFFE. These patterns check the priority order and the wrap.

// File: rtl/srf_pkg.sv
// Shared register codes for the split-byte register file.
// Assumes a 4-bit select; codes 0xB..0xE are unassigned.
package srf_pkg;

    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_ACC  = 4'h0,
        SEL_FLG  = 4'h1,
        SEL_HI0  = 4'h2,
        SEL_LO0  = 4'h3,
        SEL_HI1  = 4'h4,
        SEL_LO1  = 4'h5,
        SEL_PR0  = 4'h6,
        SEL_PR1  = 4'h7,
        SEL_STK  = 4'h8,
        SEL_FRM  = 4'h9,
        SEL_PC   = 4'hA,
        SEL_ZERO = 4'hF
    } reg_sel_e;

endpackage

// File: rtl/srf_pair.sv
// Byte-writable register pair.
// Each half has its own write enable. The lower byte also has a side
// update path (used for flags), and a port write to the lower byte
// takes precedence over it. Assumes synchronous active-low reset.
module srf_pair #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_hi,
    input  logic                  wr_lo,
    input  logic [BYTE_W-1:0]     d_hi,
    input  logic [BYTE_W-1:0]     d_lo,
    input  logic                  alt_we,
    input  logic [BYTE_W-1:0]     alt_d,
    output logic [2*BYTE_W-1:0]   q
);

    logic [BYTE_W-1:0] hi_q;
    logic [BYTE_W-1:0] lo_q;

    // Upper byte: cleared on reset, loaded on a port write.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_q <= '0;
        else if (wr_hi) hi_q <= d_hi;
    end

    // Lower byte: a port write beats the side update path.
    always_ff @(posedge clk) begin
        if (!rst_n)       lo_q <= '0;
        else if (wr_lo)   lo_q <= d_lo;
        else if (alt_we)  lo_q <= alt_d;
    end

    assign q = {hi_q, lo_q};

    // R4: a write to both halves in one cycle stores the whole word.
    p_word_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && wr_lo) |=> (q == $past({d_hi, d_lo})));

    // R10: a port write to the lower byte wins over the side update.
    p_port_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && alt_we) |=> (q[BYTE_W-1:0] == $past(d_lo)));

    // R9: a lone side update lands in the lower byte, upper byte untouched.
    p_side_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_we && !wr_lo && !wr_hi) |=>
            (q == {$past(q[2*BYTE_W-1:BYTE_W]), $past(alt_d)}));

endmodule

// File: rtl/srf_pc.sv
// Program counter register.
// Priority: load input, then port write, then increment by STEP.
// Wraps modulo 2^WORD_W. Assumes synchronous active-low reset.
module srf_pc #(
    parameter int WORD_W = 16,
    parameter int STEP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic              wr,
    input  logic [WORD_W-1:0] wr_d,
    output logic [WORD_W-1:0] q
);

    localparam logic [WORD_W-1:0] STEP_V = WORD_W'(STEP);

    // Next-PC selection in fixed priority order.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= load_val;
        else if (wr)   q <= wr_d;
        else if (inc)  q <= q + STEP_V;
    end

    // R11: a load overrides both the port write and the increment.
    p_pc_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(load_val)));

    // R11: a lone increment advances by the step, wrapping.
    p_pc_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && !wr) |=> (q == $past(q) + STEP_V));

    // R11: with nothing active the counter holds.
    p_pc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load && !wr) |=> $stable(q));

endmodule

// File: rtl/srf_rd_mux.sv
// Combinational read selector for one read port.
// Zero-extends 8-bit registers; unassigned codes and the zero code read 0.
module srf_rd_mux
    import srf_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [SEL_W-1:0]      sel,
    input  logic [BYTE_W-1:0]     acc,
    input  logic [2*BYTE_W-1:0]   pr0,
    input  logic [2*BYTE_W-1:0]   pr1,
    input  logic [2*BYTE_W-1:0]   stk,
    input  logic [2*BYTE_W-1:0]   frm,
    input  logic [2*BYTE_W-1:0]   pc,
    output logic [2*BYTE_W-1:0]   data
);

    localparam logic [BYTE_W-1:0] ZB = '0;

    // Decode the code into the selected, width-adjusted value.
    always_comb begin
        unique case (sel)
            SEL_ACC: data = {ZB, acc};
            SEL_FLG: data = {ZB, pr1[BYTE_W-1:0]};
            SEL_HI0: data = {ZB, pr0[2*BYTE_W-1:BYTE_W]};
            SEL_LO0: data = {ZB, pr0[BYTE_W-1:0]};
            SEL_HI1: data = {ZB, pr1[2*BYTE_W-1:BYTE_W]};
            SEL_LO1: data = {ZB, pr1[BYTE_W-1:0]};
            SEL_PR0: data = pr0;
            SEL_PR1: data = pr1;
            SEL_STK: data = stk;
            SEL_FRM: data = frm;
            SEL_PC:  data = pc;
            default: data = '0;
        endcase
    end

endmodule

// File: rtl/split_regfile.sv
// Split-byte register file top.
// Decodes the write port onto the accumulator, two byte-writable pairs
// (the second pair's lower byte is the flags byte), two pointer words and
// the program counter. Two read ports are served by replicated selectors.
// Assumes synchronous active-low reset and a single clock.
module split_regfile
    import srf_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int PC_STEP = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           rd_sel_a,
    output logic [2*BYTE_W-1:0]  rd_data_a,
    input  logic [3:0]           rd_sel_b,
    output logic [2*BYTE_W-1:0]  rd_data_b,
    input  logic                 wr_en,
    input  logic [3:0]           wr_sel,
    input  logic [2*BYTE_W-1:0]  wr_data,
    input  logic                 flag_we,
    input  logic [BYTE_W-1:0]    flag_d,
    input  logic                 pc_inc,
    input  logic                 pc_load,
    input  logic [2*BYTE_W-1:0]  pc_load_val,
    output logic [2*BYTE_W-1:0]  pc_q
);

    localparam int WORD_W  = 2 * BYTE_W;
    localparam int N_PAIR  = 2;
    localparam int N_WORD  = 2;
    localparam int N_RD    = 2;

    logic [BYTE_W-1:0] acc_q;
    logic [WORD_W-1:0] pair_q [N_PAIR];
    logic [WORD_W-1:0] word_q [N_WORD];
    logic [SEL_W-1:0]  rd_sel  [N_RD];
    logic [WORD_W-1:0] rd_data [N_RD];

    // Accumulator: byte register loaded from the low half of the write data.
    always_ff @(posedge clk) begin
        if (!rst_n)                        acc_q <= '0;
        else if (wr_en && wr_sel == SEL_ACC) acc_q <= wr_data[BYTE_W-1:0];
    end

    // Register pairs; pair 1 carries the flags byte in its lower half.
    for (genvar g = 0; g < N_PAIR; g++) begin : g_pair
        localparam logic [SEL_W-1:0] C_HI = (g == 0) ? SEL_HI0 : SEL_HI1;
        localparam logic [SEL_W-1:0] C_LO = (g == 0) ? SEL_LO0 : SEL_LO1;
        localparam logic [SEL_W-1:0] C_WD = (g == 0) ? SEL_PR0 : SEL_PR1;
        localparam bit HAS_FLG = (g == 1);

        logic hit_hi, hit_lo, hit_wd;
        logic [BYTE_W-1:0] d_hi;

        assign hit_wd = wr_en && (wr_sel == C_WD);
        assign hit_hi = hit_wd || (wr_en && wr_sel == C_HI);
        assign hit_lo = hit_wd || (wr_en && wr_sel == C_LO)
                      || (HAS_FLG && wr_en && wr_sel == SEL_FLG);
        assign d_hi   = hit_wd ? wr_data[WORD_W-1:BYTE_W] : wr_data[BYTE_W-1:0];

        srf_pair #(.BYTE_W(BYTE_W)) pair_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hi  (hit_hi),
            .wr_lo  (hit_lo),
            .d_hi   (d_hi),
            .d_lo   (wr_data[BYTE_W-1:0]),
            .alt_we (HAS_FLG && flag_we),
            .alt_d  (flag_d),
            .q      (pair_q[g])
        );
    end

    // Pointer words: stack then frame, codes consecutive from SEL_STK.
    for (genvar w = 0; w < N_WORD; w++) begin : g_word
        localparam logic [SEL_W-1:0] C_W = SEL_STK + SEL_W'(w);

        // Word register loaded whole from the write port.
        always_ff @(posedge clk) begin
            if (!rst_n)                    word_q[w] <= '0;
            else if (wr_en && wr_sel == C_W) word_q[w] <= wr_data;
        end
    end

    srf_pc #(.WORD_W(WORD_W), .STEP(PC_STEP)) pc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (pc_inc),
        .load     (pc_load),
        .load_val (pc_load_val),
        .wr       (wr_en && wr_sel == SEL_PC),
        .wr_d     (wr_data),
        .q        (pc_q)
    );

    assign rd_sel[0] = rd_sel_a;
    assign rd_sel[1] = rd_sel_b;

    // One independent selector per read port.
    for (genvar r = 0; r < N_RD; r++) begin : g_rd
        srf_rd_mux #(.BYTE_W(BYTE_W)) mux_i (
            .sel  (rd_sel[r]),
            .acc  (acc_q),
            .pr0  (pair_q[0]),
            .pr1  (pair_q[1]),
            .stk  (word_q[0]),
            .frm  (word_q[1]),
            .pc   (pc_q),
            .data (rd_data[r])
        );
    end

    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];

    // R7 / R8: zero and unassigned codes read zero on port A.
    p_zero_read_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel_a >= 4'hB) |-> (rd_data_a == '0));

    // R7 / R8: zero and unassigned codes read zero on port B.
    p_zero_read_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel_b >= 4'hB) |-> (rd_data_b == '0));

    // R2: byte-wide codes come out zero-extended.
    p_zext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel_a <= 4'h5) |-> (rd_data_a[WORD_W-1:BYTE_W] == '0));

    // R8: a write to an unassigned or zero code leaves all storage alone.
    p_ignored_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel >= 4'hB && !flag_we) |=>
            $stable({acc_q, pair_q[0], pair_q[1], word_q[0], word_q[1]}));

endmodule

// File: tb/split_regfile_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected port values, a monitor
// pops and compares them once the combinational reads have settled.
module split_regfile_tb_top;

    localparam int WD_CYCLES = 5000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  rd_sel_a, rd_sel_b, wr_sel;
    logic [15:0] rd_data_a, rd_data_b, wr_data, pc_load_val, pc_q;
    logic        wr_en, flag_we, pc_inc, pc_load;
    logic [7:0]  flag_d;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        int          port;
        logic [15:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     sb_ev;

    always #10 clk = ~clk;

    split_regfile dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_sel_a    (rd_sel_a),
        .rd_data_a   (rd_data_a),
        .rd_sel_b    (rd_sel_b),
        .rd_data_b   (rd_data_b),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .flag_we     (flag_we),
        .flag_d      (flag_d),
        .pc_inc      (pc_inc),
        .pc_load     (pc_load),
        .pc_load_val (pc_load_val),
        .pc_q        (pc_q)
    );

    // Monitor: compare every queued item against the live outputs.
    initial begin
        forever begin
            @(sb_ev);
            #2;
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [15:0] act;
                it  = sb_q.pop_front();
                act = (it.port == 0) ? rd_data_a : (it.port == 1) ? rd_data_b : pc_q;
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s port%0d actual=%h expected=%h", it.tag, it.port, act, it.exp);
                end
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Drive all write-side inputs for exactly one clock edge.
    task automatic cyc(input logic we, input logic [3:0] sel, input logic [15:0] d,
                       input logic fwe, input logic [7:0] fd,
                       input logic inc, input logic ld, input logic [15:0] ldv);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = d;
        flag_we = fwe; flag_d = fd;
        pc_inc = inc; pc_load = ld; pc_load_val = ldv;
        @(negedge clk);
        wr_en = 1'b0; flag_we = 1'b0; pc_inc = 1'b0; pc_load = 1'b0;
    endtask

    task automatic wr(input logic [3:0] sel, input logic [15:0] d);
        cyc(1'b1, sel, d, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0);
    endtask

    // Queue expected values for both read ports and hand off to the monitor.
    task automatic chk2(input logic [3:0] sa, input logic [15:0] ea,
                        input logic [3:0] sb, input logic [15:0] eb, input string tag);
        @(negedge clk);
        rd_sel_a = sa; rd_sel_b = sb;
        sb_q.push_back('{0, ea, tag});
        sb_q.push_back('{1, eb, tag});
        -> sb_ev;
        #5;
    endtask

    task automatic chk_pc(input logic [15:0] e, input string tag);
        @(negedge clk);
        sb_q.push_back('{2, e, tag});
        -> sb_ev;
        #5;
    endtask

    // Watchdog: a hung run counts as a miscompare and still reports.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    // Stimulus.
    initial begin
        rst_n = 1'b0; rd_sel_a = 4'h0; rd_sel_b = 4'h0;
        wr_en = 1'b0; wr_sel = 4'h0; wr_data = 16'h0;
        flag_we = 1'b0; flag_d = 8'h0; pc_inc = 1'b0; pc_load = 1'b0; pc_load_val = 16'h0;
        // Load junk during reset to show reset dominates.
        repeat (2) @(negedge clk);
        wr_en = 1'b1; wr_sel = 4'h8; wr_data = 16'hFFFF; pc_inc = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; pc_inc = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every code reads zero after reset.
        for (int s = 0; s < 16; s += 2)
            chk2(4'(s), 16'h0, 4'(s + 1), 16'h0, "R1 reset read");
        chk_pc(16'h0000, "R1 reset pc");

        // R2: accumulator drops upper write bits, read zero-extended.
        wr(4'h0, 16'hAB5C);
        chk2(4'h0, 16'h005C, 4'hF, 16'h0, "R2 acc zext");

        // R3: byte writes into pair 0, then word read.
        wr(4'h2, 16'hFF12);
        wr(4'h3, 16'hEE34);
        chk2(4'h6, 16'h1234, 4'h2, 16'h0012, "R3 byte halves");

        // R4: word write to pair 1, byte reads of its halves.
        wr(4'h7, 16'hBEEF);
        chk2(4'h4, 16'h00BE, 4'h5, 16'h00EF, "R4 word then bytes");
        // R5: flags name shows the shared lower byte.
        chk2(4'h1, 16'h00EF, 4'h3, 16'h0034, "R5 flags alias read");
        wr(4'h1, 16'h0055);
        chk2(4'h7, 16'hBE55, 4'h5, 16'h0055, "R5 flags alias write");

        // R6: pointer words and PC via write port.
        wr(4'h8, 16'h1111);
        wr(4'h9, 16'h2222);
        wr(4'hA, 16'h3330);
        chk2(4'h8, 16'h1111, 4'h9, 16'h2222, "R6 stack frame");
        chk2(4'hA, 16'h3330, 4'h6, 16'h1234, "R6 pc read");
        chk_pc(16'h3330, "R6 pc out");

        // R7: zero code write ignored.
        wr(4'hF, 16'hFFFF);
        chk2(4'hF, 16'h0000, 4'h0, 16'h005C, "R7 zero code");
        chk2(4'h6, 16'h1234, 4'h7, 16'hBE55, "R7 nothing clobbered");

        // R8: unassigned codes read zero, writes have no effect.
        for (int s = 11; s < 15; s++) wr(4'(s), 16'hFFFF);
        chk2(4'hB, 16'h0, 4'hC, 16'h0, "R8 unused read");
        chk2(4'hD, 16'h0, 4'hE, 16'h0, "R8 unused read");
        chk2(4'h8, 16'h1111, 4'h9, 16'h2222, "R8 pointers kept");
        chk_pc(16'h3330, "R8 pc kept");

        // R9: lone flag update.
        cyc(1'b0, 4'h0, 16'h0, 1'b1, 8'hA5, 1'b0, 1'b0, 16'h0);
        chk2(4'h1, 16'h00A5, 4'h7, 16'hBEA5, "R9 flag update");

        // R10: write wins on the shared byte, by each of its three names.
        cyc(1'b1, 4'h5, 16'h003C, 1'b1, 8'h77, 1'b0, 1'b0, 16'h0);
        chk2(4'h1, 16'h003C, 4'h7, 16'hBE3C, "R10 lo-byte wins");
        cyc(1'b1, 4'h7, 16'hCAFE, 1'b1, 8'h11, 1'b0, 1'b0, 16'h0);
        chk2(4'h7, 16'hCAFE, 4'h1, 16'h00FE, "R10 word wins");
        cyc(1'b1, 4'h1, 16'h00C3, 1'b1, 8'h5A, 1'b0, 1'b0, 16'h0);
        chk2(4'h1, 16'h00C3, 4'h4, 16'h00CA, "R10 flags name wins");
        cyc(1'b1, 4'h4, 16'h0099, 1'b1, 8'h11, 1'b0, 1'b0, 16'h0);
        chk2(4'h7, 16'h9911, 4'h6, 16'h1234, "R10 neighbour write plus flags");

        // R11: increment, then the priority order, then wrap.
        repeat (3) cyc(1'b0, 4'h0, 16'h0, 1'b0, 8'h0, 1'b1, 1'b0, 16'h0);
        chk_pc(16'h3336, "R11 inc x3");
        cyc(1'b0, 4'h0, 16'h0, 1'b0, 8'h0, 1'b1, 1'b1, 16'h0100);
        chk_pc(16'h0100, "R11 load over inc");
        cyc(1'b1, 4'hA, 16'h0200, 1'b0, 8'h0, 1'b1, 1'b0, 16'h0);
        chk_pc(16'h0200, "R11 write over inc");
        cyc(1'b1, 4'hA, 16'h1234, 1'b0, 8'h0, 1'b0, 1'b1, 16'h0ABC);
        chk_pc(16'h0ABC, "R11 load over write");
        cyc(1'b0, 4'h0, 16'h0, 1'b0, 8'h0, 1'b0, 1'b1, 16'hFFFE);
        cyc(1'b0, 4'h0, 16'h0, 1'b0, 8'h0, 1'b1, 1'b0, 16'h0);
        chk_pc(16'h0000, "R11 wrap");
        repeat (2) @(negedge clk);
        chk_pc(16'h0000, "R11 hold");

        // R12: two ports, unrelated codes, same cycle.
        chk2(4'h0, 16'h005C, 4'h9, 16'h2222, "R12 dual port");
        chk2(4'h3, 16'h0034, 4'h5, 16'h0011, "R12 dual port bytes");

        done = 1'b1;
        summary();
    end

endmodule